// File: doc/BRIEF.md
# Packed Byte Permute and Align Unit

This block is the byte-movement datapath of a 128-bit vector integer unit. It treats each operand as sixteen byte lanes and performs one of two operations chosen by the secondary opcode byte of the instruction. The **permute** operation fills each result lane from a lane of the data operand. The lane is chosen by the matching byte of a control operand, so the operation acts as a sixteen-entry table lookup. The **align** operation joins the two operands into a 32-byte value, shifts it right by a whole number of bytes given in an 8-bit immediate, and keeps the low sixteen bytes.

The decoder only maps the secondary opcode byte onto an operation. Fetch, memory operands, the 64-bit register forms and exceptions belong to the surrounding pipeline. With the default configuration the result is held in one output register, and a valid flag follows the issue strobe by one cycle. Setting `OUT_REG` to 0 gives a purely combinational path.

Top module: `byte_shuffle_unit`

## Requirements
- R1: For permute, if bit 7 of control byte i (`src_b` bits 8i+7) is clear, result byte i equals byte k of `src_a`, where k is control bits 3:0. Control bits 6:4 have no effect.
- R2: For permute, a control byte with bit 7 set gives a zero result byte in that lane, whatever the other control bits are.
- R3: For align with `imm` from 0 to 15, the result is the low 16 bytes of {`src_a`,`src_b`} (`src_a` in the upper half) shifted right by `imm` bytes. Result byte i equals `src_b` byte i+imm while i+imm < 16, and `src_a` byte i+imm-16 after that.
- R4: For align with `imm` from 16 to 31, result byte i equals `src_a` byte i+imm-16 while that index is below 16. The remaining upper bytes are zero, and no byte of `src_b` appears.
- R5: For align with `imm` of 32 or more, the result is all zero.
- R6: Opcode byte 0x00 selects permute and 0x0F selects align. Any other opcode byte produces an all-zero result.
- R7: With the output register present, `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high.
- R8: While `in_valid` is low, `result` keeps its last value, whatever happens on the operand, opcode and immediate inputs.
- R9: During and straight after reset, `out_valid` is 0 and `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the operands on this cycle |
| opc | input | 8 | Secondary opcode byte that selects the operation |
| imm | input | 8 | Byte shift count used by align |
| src_a | input | 128 | Table operand for permute, upper half for align |
| src_b | input | 128 | Control mask for permute, lower half for align |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 128 | Sixteen result bytes |

## Verification
The assertions check four things on every cycle:
- the one-cycle valid timing and the hold of the result while idle;
- zeroing of any lane whose control byte has bit 7 set;
- the all-zero result for large align counts and for unknown opcodes;
- the pass-through of the low operand at an align count of zero.

Only the bench scenarios can show that each lane takes the right byte. The bench sweeps all 256 immediate values and many random control masks, including masks with noise in bits 6:4, against a byte-level reference model.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam logic [7:0]  CODE_PERM  = 8'h00;
    localparam logic [7:0]  CODE_ALIGN = 8'h0F;

    typedef enum logic [1:0] {
        OPS_NONE  = 2'd0,
        OPS_PERM  = 2'd1,
        OPS_ALIGN = 2'd2
    } op_sel_e;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
(
    input  logic [7:0] opc,
    output op_sel_e    op_sel
);
    always_comb begin
        unique case (opc)
            CODE_PERM:  op_sel = OPS_PERM;
            CODE_ALIGN: op_sel = OPS_ALIGN;
            default:    op_sel = OPS_NONE;
        endcase
    end
endmodule

// File: rtl/bsu_permute.sv
module bsu_permute #(
    parameter int unsigned LANES  = 16,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] table_in,
    input  logic [LANES*LANE_W-1:0] ctrl_in,
    output logic [LANES*LANE_W-1:0] perm_out
);
    localparam int unsigned IDX_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] ctl;
        logic [IDX_W-1:0]  sel;
        assign ctl = ctrl_in[g*LANE_W +: LANE_W];
        assign sel = ctl[IDX_W-1:0];
        always_comb begin
            if (ctl[LANE_W-1]) perm_out[g*LANE_W +: LANE_W] = '0;
            else               perm_out[g*LANE_W +: LANE_W] = table_in[sel*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/bsu_align.sv
module bsu_align #(
    parameter int unsigned LANES  = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned IMM_W  = 8
) (
    input  logic [LANES*LANE_W-1:0] hi_in,
    input  logic [LANES*LANE_W-1:0] lo_in,
    input  logic [IMM_W-1:0]        shamt,
    output logic [LANES*LANE_W-1:0] align_out
);
    localparam int unsigned IDX_W = $clog2(LANES);
    localparam int unsigned POS_W = IMM_W + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [POS_W-1:0] pos;
        logic [IDX_W-1:0] sub;
        assign pos = {1'b0, shamt} + POS_W'(g);
        assign sub = pos[IDX_W-1:0];
        always_comb begin
            if (pos < POS_W'(LANES))
                align_out[g*LANE_W +: LANE_W] = lo_in[sub*LANE_W +: LANE_W];
            else if (pos < POS_W'(2*LANES))
                align_out[g*LANE_W +: LANE_W] = hi_in[sub*LANE_W +: LANE_W];
            else
                align_out[g*LANE_W +: LANE_W] = '0;
        end
    end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
    import bsu_pkg::*;
#(
    parameter int unsigned LANES   = 16,
    parameter int unsigned IMM_W   = 8,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              opc,
    input  logic [IMM_W-1:0]        imm,
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    output logic                    out_valid,
    output logic [LANES*BYTE_W-1:0] result
);
    localparam int unsigned DW = LANES * BYTE_W;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_st_t;

    op_sel_e       op_sel;
    logic [DW-1:0] perm_res;
    logic [DW-1:0] align_res;
    logic [DW-1:0] path_res;

    bsu_decode u_dec (.opc(opc), .op_sel(op_sel));

    bsu_permute #(.LANES(LANES), .LANE_W(BYTE_W)) u_perm (
        .table_in(src_a), .ctrl_in(src_b), .perm_out(perm_res)
    );

    bsu_align #(.LANES(LANES), .LANE_W(BYTE_W), .IMM_W(IMM_W)) u_align (
        .hi_in(src_a), .lo_in(src_b), .shamt(imm), .align_out(align_res)
    );

    always_comb begin
        unique case (op_sel)
            OPS_PERM:  path_res = perm_res;
            OPS_ALIGN: path_res = align_res;
            default:   path_res = '0;
        endcase
    end

    if (OUT_REG) begin : g_reg
        out_st_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) st_d.data = path_res;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign out_valid = st_q.vld;
        assign result    = st_q.data;

        // R7: valid follows issue by exactly one cycle
        a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R8: idle cycles leave the result untouched
        a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
        // R5: large align counts clear the result
        a_r5_align_far_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opc == CODE_ALIGN && imm >= IMM_W'(2*LANES)) |=> (result == '0));
        // R6: unknown opcodes give zero
        a_r6_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opc != CODE_PERM && opc != CODE_ALIGN) |=> (result == '0));
        // R3: a zero count passes the low operand through
        a_r3_align_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opc == CODE_ALIGN && imm == '0) |=> (result == $past(src_b)));

        for (genvar g = 0; g < LANES; g++) begin : g_chk
            // R2: a control byte with its top bit set zeroes its lane
            a_r2_perm_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && opc == CODE_PERM && src_b[g*BYTE_W + BYTE_W-1])
                |=> (result[g*BYTE_W +: BYTE_W] == '0));
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = path_res;
    end
endmodule

// File: tb/tb_byte_shuffle_unit.sv
`timescale 1ns/1ps
module tb_byte_shuffle_unit;
    localparam int LANES = 16;
    localparam int DW    = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [7:0]    opc;
    logic [7:0]    imm;
    logic [DW-1:0] src_a;
    logic [DW-1:0] src_b;
    logic          out_valid;
    logic [DW-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    byte_shuffle_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opc(opc), .imm(imm),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [DW-1:0] ref_perm(input logic [DW-1:0] a, input logic [DW-1:0] c);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [7:0] cb = c[i*8 +: 8];
            if (cb[7] == 1'b0) r[i*8 +: 8] = a[(cb % 16)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] ref_align(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                                input int sh);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < LANES; i++) begin
            int p = i + sh;
            if (p < 16)      r[i*8 +: 8] = b[p*8 +: 8];
            else if (p < 32) r[i*8 +: 8] = a[(p-16)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] o, input logic [7:0] i8,
                         input logic [DW-1:0] a, input logic [DW-1:0] b, input logic v);
        @(negedge clk);
        opc = o; imm = i8; src_a = a; src_b = b; in_valid = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] a, b, e, held;
        rst_n = 1'b0; in_valid = 1'b0; opc = 8'h00; imm = 8'h00;
        src_a = '0; src_b = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", {127'd0, out_valid}, '0);
        check("R9 reset result", result, '0);
        @(negedge clk); rst_n = 1'b1;

        // R1: identity, reverse and noisy bits 6:4
        a = rnd128();
        for (int i = 0; i < LANES; i++) b[i*8 +: 8] = 8'(i);
        issue(8'h00, 8'h00, a, b, 1'b1);
        check("R1 perm identity", result, a);
        check("R7 valid after issue", {127'd0, out_valid}, {127'd0, 1'b1});
        for (int i = 0; i < LANES; i++) b[i*8 +: 8] = 8'(15 - i) | 8'h70;
        issue(8'h00, 8'h00, a, b, 1'b1);
        check("R1 perm reverse bits6:4 ignored", result, ref_perm(a, b));
        // R2: all lanes zeroed
        issue(8'h00, 8'h00, a, {16{8'h83}}, 1'b1);
        check("R2 perm all zero", result, '0);
        for (int t = 0; t < 300; t++) begin
            a = rnd128(); b = rnd128();
            issue(8'h00, 8'($urandom), a, b, 1'b1);
            check("R1 R2 perm random", result, ref_perm(a, b));
        end

        // R3 R4 R5: every immediate value
        for (int s = 0; s < 256; s++) begin
            a = rnd128(); b = rnd128();
            issue(8'h0F, 8'(s), a, b, 1'b1);
            e = ref_align(a, b, s);
            if (s < 16)      check("R3 align low window", result, e);
            else if (s < 32) check("R4 align high only", result, e);
            else             check("R5 align far zero", result, '0);
        end
        issue(8'h0F, 8'd16, a, b, 1'b1);
        check("R4 align 16 equals src_a", result, a);

        // R6: unknown opcodes
        for (int o = 1; o < 256; o++) begin
            if (o == 8'h0F) continue;
            issue(8'(o), 8'd3, rnd128(), rnd128(), 1'b1);
            check("R6 unknown opcode zero", result, '0);
        end

        // R7 R8: idle cycles keep the result
        a = rnd128(); b = rnd128();
        issue(8'h0F, 8'd5, a, b, 1'b1);
        held = ref_align(a, b, 5);
        check("R3 align before idle", result, held);
        for (int t = 0; t < 4; t++) begin
            issue(8'h00, 8'($urandom), rnd128(), rnd128(), 1'b0);
            check("R8 hold while idle", result, held);
            check("R7 no valid while idle", {127'd0, out_valid}, '0);
        end

        // R9: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 reset clears result", result, '0);
        check("R9 reset clears valid", {127'd0, out_valid}, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule